// File: doc/BRIEF.md
# Thermal Fault and Alarm Monitor

This block turns three temperature readings into protection actions and host-visible event status for a charge-pump style charger controller. Two inputs are thermistor divider codes, one for the cable connector and one for the battery pack. Each code is a fraction of the divider pull-up voltage, and it falls as the part heats up. The third input is a die temperature code, which rises with heat. Each reading is taken in on a sample strobe and compared with its own programmable fault threshold.

A fault on any enabled channel stops the converter and drops charge-enable. Both stay off until the host writes charge-enable again and no enabled fault is active at that time. Alarms are softer. One alarm is a band just above each thermistor fault threshold. The other is a separate die alarm threshold. Alarms only report to the host. Every event has a live status bit, a sticky flag bit and a mask bit. An active-low interrupt pulses whenever an unmasked flag sets.

The charge-enable control is a three-state machine:
- ST_IDLE: the host has charging off.
- ST_RUN: charging and the converter are on.
- ST_TRIP: a fault has latched charging off.

Transitions:
- IDLE→RUN and TRIP→RUN: a host write of 1 with no enabled fault active.
- RUN→TRIP: any enabled fault condition is active. This transition has priority.
- RUN→IDLE and TRIP→IDLE: a host write of 0.

Top module: `thermal_guard`

## Requirements
- R1: After reset, chg_en and conv_on are 0, evt_stat and evt_flag are 0, and int_n is 1.
- R2: A thermistor fault is present when the code is at or below its fault threshold. The connector fault is event bit 0 and the battery fault is event bit 1.
- R3: The shared thermistor alarm, event bit 3, is present when either code lies above its threshold and no more than 2^TW/10 codes above it. That band equals 5% of pull-up on a 0–50% code range, and its top saturates at the largest code.
- R4: The die fault, event bit 2, is present when the die code is at or above the die fault threshold.
- R5: The die alarm, event bit 4, is present when the die code is strictly above the die alarm threshold.
- R6: While a channel's disable input is 1, that channel contributes neither its fault nor its alarm.
- R7: When an enabled fault condition is active while running, chg_en and conv_on drop to 0 on the next clock. They stay 0 after the condition clears.
- R8: A host write of 1 sets chg_en and conv_on on the next clock only if no enabled fault condition is active. Otherwise the write is ignored.
- R9: Alarms never change chg_en or conv_on.
- R10: On each sample strobe the live conditions are captured. evt_stat is the captured condition with masked bits forced to 0. A masked fault still stops charging.
- R11: evt_flag bits set on a sample where the unmasked condition is present. They stay set until a flag_clr strobe, and a set in the same cycle as a clear wins.
- R12: Whenever any flag bit goes from 0 to 1, int_n is driven low for INT_PULSE clocks starting on the next clock.
- R13: A host write of 0 clears chg_en and conv_on on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample strobe for all three codes |
| bus_code | input | TW | Connector thermistor code |
| bat_code | input | TW | Battery thermistor code |
| die_code | input | DW | Die temperature code |
| bus_flt_thr | input | TW | Connector fault threshold |
| bat_flt_thr | input | TW | Battery fault threshold |
| die_flt_thr | input | DW | Die fault threshold |
| die_alm_thr | input | DW | Die alarm threshold |
| bus_flt_dis | input | 1 | Connector channel disable |
| bat_flt_dis | input | 1 | Battery channel disable |
| die_flt_dis | input | 1 | Die channel disable |
| evt_mask | input | 5 | Per-event mask |
| flag_clr | input | 1 | Host read strobe that clears all flags |
| cen_wr | input | 1 | Charge-enable write strobe |
| cen_wdata | input | 1 | Charge-enable write value |
| chg_en | output | 1 | Charge-enable bit |
| conv_on | output | 1 | Converter run |
| evt_stat | output | 5 | Live event status |
| evt_flag | output | 5 | Sticky event flags |
| int_n | output | 1 | Active-low interrupt pulse |

## Verification
The bench builds the block with TW=10, DW=8 and INT_PULSE=3. With TW=10 the alarm band is 102 codes wide. This lets the thresholds of 300 and 400 be probed on both sides of the fault and band edges with exact integer codes. The short pulse length lets the bench count every interrupt cycle. The 8-bit die code lets the die fault and die alarm thresholds be approached one code at a time.

// File: rtl/thermal_pkg.sv
package thermal_pkg;

    localparam int NEV        = 5;
    localparam int EV_BUS_FLT = 0;
    localparam int EV_BAT_FLT = 1;
    localparam int EV_DIE_FLT = 2;
    localparam int EV_TS_ALM  = 3;
    localparam int EV_DIE_ALM = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_TRIP = 2'd2
    } chg_state_e;

endpackage

// File: rtl/therm_chan_cmp.sv
module therm_chan_cmp #(
    parameter int W       = 10,
    parameter bit HOT_LOW = 1'b1
) (
    input  logic [W-1:0] sample,
    input  logic [W-1:0] flt_thr,
    input  logic [W-1:0] alm_thr,
    input  logic         dis,
    output logic         fault,
    output logic         alarm
);

    generate
        if (HOT_LOW) begin : g_hot_low
            // code falls as temperature rises; alarm band sits just above the fault level
            always_comb begin
                fault = !dis && (sample <= flt_thr);
                alarm = !dis && (sample > flt_thr) && (sample <= alm_thr);
            end
        end else begin : g_hot_high
            always_comb begin
                fault = !dis && (sample >= flt_thr);
                alarm = !dis && (sample > alm_thr);
            end
        end
    endgenerate

endmodule

// File: rtl/therm_evt_bank.sv
module therm_evt_bank #(
    parameter int NEV       = 5,
    parameter int INT_PULSE = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           smp_valid,
    input  logic [NEV-1:0] cond_in,
    input  logic [NEV-1:0] mask,
    input  logic           flag_clr,
    output logic [NEV-1:0] cond_q,
    output logic [NEV-1:0] stat,
    output logic [NEV-1:0] flag,
    output logic           int_n
);

    localparam int CW = $clog2(INT_PULSE + 1);
    localparam logic [CW-1:0] PULSE_LD = CW'(INT_PULSE);

    logic [NEV-1:0] flag_nxt;
    logic [NEV-1:0] set_vec;
    logic [CW-1:0]  pulse_cnt;
    logic           new_flag;

    always_comb begin
        set_vec  = smp_valid ? (cond_in & ~mask) : '0;
        flag_nxt = (flag_clr ? '0 : flag) | set_vec;
        new_flag = |(flag_nxt & ~flag);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cond_q <= '0;
            flag   <= '0;
        end else begin
            if (smp_valid) cond_q <= cond_in;
            flag <= flag_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          pulse_cnt <= '0;
        else if (new_flag)   pulse_cnt <= PULSE_LD;
        else if (pulse_cnt != '0) pulse_cnt <= pulse_cnt - 1'b1;
    end

    assign stat  = cond_q & ~mask;
    assign int_n = (pulse_cnt == '0);

endmodule

// File: rtl/therm_chg_fsm.sv
module therm_chg_fsm
    import thermal_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fault_act,
    input  logic cen_wr,
    input  logic cen_wdata,
    output logic chg_en,
    output logic conv_on
);

    chg_state_e state_q, state_d;
    logic       req_on, req_off;

    assign req_on  = cen_wr && cen_wdata && !fault_act;
    assign req_off = cen_wr && !cen_wdata;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_on) state_d = ST_RUN;
            ST_RUN: begin
                if (fault_act)    state_d = ST_TRIP;
                else if (req_off) state_d = ST_IDLE;
            end
            ST_TRIP: begin
                if (req_on)       state_d = ST_RUN;
                else if (req_off) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        chg_en  = 1'b0;
        conv_on = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                chg_en  = 1'b1;
                conv_on = 1'b1;
            end
            ST_IDLE, ST_TRIP: begin
                chg_en  = 1'b0;
                conv_on = 1'b0;
            end
            default: begin
                chg_en  = 1'b0;
                conv_on = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/thermal_guard.sv
module thermal_guard
    import thermal_pkg::*;
#(
    parameter int TW        = 10,
    parameter int DW        = 8,
    parameter int INT_PULSE = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_valid,
    input  logic [TW-1:0] bus_code,
    input  logic [TW-1:0] bat_code,
    input  logic [DW-1:0] die_code,
    input  logic [TW-1:0] bus_flt_thr,
    input  logic [TW-1:0] bat_flt_thr,
    input  logic [DW-1:0] die_flt_thr,
    input  logic [DW-1:0] die_alm_thr,
    input  logic          bus_flt_dis,
    input  logic          bat_flt_dis,
    input  logic          die_flt_dis,
    input  logic [4:0]    evt_mask,
    input  logic          flag_clr,
    input  logic          cen_wr,
    input  logic          cen_wdata,
    output logic          chg_en,
    output logic          conv_on,
    output logic [4:0]    evt_stat,
    output logic [4:0]    evt_flag,
    output logic          int_n
);

    // band of 5% pull-up over a code range spanning 0..50%: one tenth of full scale
    localparam int            BAND    = (2 ** TW) / 10;
    localparam logic [TW:0]   BAND_W  = (TW + 1)'(BAND);
    localparam logic [TW:0]   CODE_MX = {1'b0, {TW{1'b1}}};

    logic [TW-1:0] ts_code [2];
    logic [TW-1:0] ts_thr  [2];
    logic [TW-1:0] ts_alm  [2];
    logic          ts_dis  [2];
    logic [1:0]    ts_flt, ts_almv;
    logic          die_flt, die_alm;
    logic [NEV-1:0] cond_now, cond_q;
    logic          fault_act;

    assign ts_code[0] = bus_code;
    assign ts_code[1] = bat_code;
    assign ts_thr[0]  = bus_flt_thr;
    assign ts_thr[1]  = bat_flt_thr;
    assign ts_dis[0]  = bus_flt_dis;
    assign ts_dis[1]  = bat_flt_dis;

    generate
        for (genvar g = 0; g < 2; g++) begin : g_ts
            logic [TW:0] top_sum;
            assign top_sum   = {1'b0, ts_thr[g]} + BAND_W;
            assign ts_alm[g] = (top_sum > CODE_MX) ? {TW{1'b1}} : top_sum[TW-1:0];

            therm_chan_cmp #(.W(TW), .HOT_LOW(1'b1)) u_ts (
                .sample  (ts_code[g]),
                .flt_thr (ts_thr[g]),
                .alm_thr (ts_alm[g]),
                .dis     (ts_dis[g]),
                .fault   (ts_flt[g]),
                .alarm   (ts_almv[g])
            );
        end
    endgenerate

    therm_chan_cmp #(.W(DW), .HOT_LOW(1'b0)) u_die (
        .sample  (die_code),
        .flt_thr (die_flt_thr),
        .alm_thr (die_alm_thr),
        .dis     (die_flt_dis),
        .fault   (die_flt),
        .alarm   (die_alm)
    );

    always_comb begin
        cond_now             = '0;
        cond_now[EV_BUS_FLT] = ts_flt[0];
        cond_now[EV_BAT_FLT] = ts_flt[1];
        cond_now[EV_DIE_FLT] = die_flt;
        cond_now[EV_TS_ALM]  = |ts_almv;
        cond_now[EV_DIE_ALM] = die_alm;
    end

    therm_evt_bank #(.NEV(NEV), .INT_PULSE(INT_PULSE)) u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .cond_in   (cond_now),
        .mask      (evt_mask),
        .flag_clr  (flag_clr),
        .cond_q    (cond_q),
        .stat      (evt_stat),
        .flag      (evt_flag),
        .int_n     (int_n)
    );

    // faults act regardless of masking
    assign fault_act = cond_q[EV_BUS_FLT] | cond_q[EV_BAT_FLT] | cond_q[EV_DIE_FLT];

    therm_chg_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .fault_act (fault_act),
        .cen_wr    (cen_wr),
        .cen_wdata (cen_wdata),
        .chg_en    (chg_en),
        .conv_on   (conv_on)
    );

endmodule

// File: rtl/thermal_guard_chk.sv
module thermal_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       fault_act,
    input logic       cen_wr,
    input logic       cen_wdata,
    input logic       flag_clr,
    input logic       chg_en,
    input logic [4:0] evt_mask,
    input logic [4:0] evt_stat,
    input logic [4:0] evt_flag,
    input logic       int_n
);

    // R7
    fault_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_act |=> !chg_en);

    // R8
    enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chg_en) |-> ($past(cen_wr) && $past(cen_wdata) && !$past(fault_act)));

    // R13
    host_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cen_wr && !cen_wdata) |=> !chg_en);

    // R10
    stat_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_stat & evt_mask) == 5'b0);

    // R11
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(evt_flag) & ~evt_flag) != 5'b0) |-> $past(flag_clr));

    // R12
    int_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(int_n) |-> ((evt_flag & ~$past(evt_flag)) != 5'b0));

endmodule

bind thermal_guard thermal_guard_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fault_act (fault_act),
    .cen_wr    (cen_wr),
    .cen_wdata (cen_wdata),
    .flag_clr  (flag_clr),
    .chg_en    (chg_en),
    .evt_mask  (evt_mask),
    .evt_stat  (evt_stat),
    .evt_flag  (evt_flag),
    .int_n     (int_n)
);

// File: tb/thermal_guard_tb_top.sv
module thermal_guard_tb_top;

    localparam int TW = 10;
    localparam int DW = 8;
    localparam int IP = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          smp_valid = 1'b0;
    logic [TW-1:0] bus_code = '1, bat_code = '1;
    logic [DW-1:0] die_code = '0;
    logic [TW-1:0] bus_flt_thr = 10'd300, bat_flt_thr = 10'd400;
    logic [DW-1:0] die_flt_thr = 8'd120, die_alm_thr = 8'd100;
    logic          bus_flt_dis = 1'b0, bat_flt_dis = 1'b0, die_flt_dis = 1'b0;
    logic [4:0]    evt_mask = '0;
    logic          flag_clr = 1'b0, cen_wr = 1'b0, cen_wdata = 1'b0;
    logic          chg_en, conv_on, int_n;
    logic [4:0]    evt_stat, evt_flag;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    thermal_guard #(.TW(TW), .DW(DW), .INT_PULSE(IP)) dut_i (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
        .bus_code(bus_code), .bat_code(bat_code), .die_code(die_code),
        .bus_flt_thr(bus_flt_thr), .bat_flt_thr(bat_flt_thr),
        .die_flt_thr(die_flt_thr), .die_alm_thr(die_alm_thr),
        .bus_flt_dis(bus_flt_dis), .bat_flt_dis(bat_flt_dis), .die_flt_dis(die_flt_dis),
        .evt_mask(evt_mask), .flag_clr(flag_clr),
        .cen_wr(cen_wr), .cen_wdata(cen_wdata),
        .chg_en(chg_en), .conv_on(conv_on),
        .evt_stat(evt_stat), .evt_flag(evt_flag), .int_n(int_n)
    );

    // {bus code, bat code, die code, expected stat}; thresholds 300/400/120, die alarm 100
    localparam int NV = 14;
    localparam logic [32:0] VEC [NV] = '{
        {10'd600, 10'd600, 8'd50,  5'b00000},
        {10'd300, 10'd600, 8'd50,  5'b00001},
        {10'd301, 10'd600, 8'd50,  5'b01000},
        {10'd402, 10'd600, 8'd50,  5'b01000},
        {10'd403, 10'd600, 8'd50,  5'b00000},
        {10'd600, 10'd400, 8'd50,  5'b00010},
        {10'd600, 10'd502, 8'd50,  5'b01000},
        {10'd600, 10'd503, 8'd50,  5'b00000},
        {10'd600, 10'd600, 8'd100, 5'b00000},
        {10'd600, 10'd600, 8'd101, 5'b10000},
        {10'd600, 10'd600, 8'd119, 5'b10000},
        {10'd600, 10'd600, 8'd120, 5'b10100},
        {10'd0,   10'd0,   8'd255, 5'b10111},
        {10'd350, 10'd450, 8'd110, 5'b11000}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_sample(input int bus, input int bat, input int die);
        @(negedge clk);
        bus_code  = TW'(bus);
        bat_code  = TW'(bat);
        die_code  = DW'(die);
        smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic cen_write(input logic v);
        @(negedge clk);
        cen_wr    = 1'b1;
        cen_wdata = v;
        @(negedge clk);
        cen_wr    = 1'b0;
    endtask

    task automatic clr_flags();
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    initial begin
        #(20 * 100000);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R1 reset values
        chk("R1 chg_en", chg_en, 0);
        chk("R1 conv_on", conv_on, 0);
        chk("R1 stat", evt_stat, 0);
        chk("R1 flag", evt_flag, 0);
        chk("R1 int_n", int_n, 1);
        rst_n = 1'b1;

        // R2 R3 R4 R5 threshold table
        for (int i = 0; i < NV; i++) begin
            do_sample(int'(VEC[i][32:23]), int'(VEC[i][22:13]), int'(VEC[i][12:5]));
            chk($sformatf("R2/R3/R4/R5 vector %0d", i), evt_stat, int'(VEC[i][4:0]));
        end

        clr_flags();
        chk("R11 flag cleared", evt_flag, 0);

        cen_write(1'b1);
        chk("R8 enable without fault", chg_en, 1);
        chk("R8 converter on", conv_on, 1);

        // R12 interrupt on a new flag, R9 alarm keeps charging
        do_sample(600, 600, 110);
        n = 0;
        while (int_n == 1'b0 && n < 20) begin
            n++;
            @(negedge clk);
        end
        chk("R12 int_n low cycles", n, IP);
        chk("R9 alarm keeps chg_en", chg_en, 1);
        chk("R9 alarm keeps conv_on", conv_on, 1);

        // R7 trip
        do_sample(200, 600, 50);
        @(negedge clk);
        chk("R7 chg_en after fault", chg_en, 0);
        chk("R7 conv_on after fault", conv_on, 0);
        cen_write(1'b1);
        chk("R8 write ignored under fault", chg_en, 0);
        do_sample(600, 600, 50);
        @(negedge clk);
        chk("R7 latched after clear", chg_en, 0);
        cen_write(1'b1);
        chk("R7 restart after clear", chg_en, 1);

        // R6 disable bits
        @(negedge clk) bus_flt_dis = 1'b1;
        do_sample(0, 600, 50);
        chk("R6 bus fault disabled", evt_stat, 0);
        do_sample(350, 600, 50);
        chk("R6 bus alarm disabled", evt_stat, 0);
        @(negedge clk);
        chk("R6 chg_en kept", chg_en, 1);
        bus_flt_dis = 1'b0;
        die_flt_dis = 1'b1;
        do_sample(600, 600, 200);
        chk("R6 die disabled", evt_stat, 0);
        @(negedge clk);
        chk("R6 chg_en kept die", chg_en, 1);
        die_flt_dis = 1'b0;

        // R10 masking
        clr_flags();
        evt_mask = 5'b00010;
        do_sample(600, 300, 50);
        chk("R10 masked stat", evt_stat, 0);
        chk("R10 masked flag", evt_flag, 0);
        @(negedge clk);
        chk("R10 masked fault trips", chg_en, 0);
        evt_mask = 5'b00000;
        #1;
        chk("R10 unmasked stat", evt_stat, 5'b00010);

        // R11 sticky flags
        clr_flags();
        do_sample(600, 600, 50);
        chk("R11 flag after safe", evt_flag, 0);
        do_sample(600, 600, 200);
        chk("R11 flag set", evt_flag, 5'b10100);
        do_sample(600, 600, 50);
        chk("R11 stat live", evt_stat, 0);
        chk("R11 flag sticky", evt_flag, 5'b10100);
        clr_flags();
        chk("R11 flag cleared", evt_flag, 0);

        // R13 host off
        cen_write(1'b1);
        chk("R13 on before off", chg_en, 1);
        cen_write(1'b0);
        chk("R13 chg_en off", chg_en, 0);
        chk("R13 conv_on off", conv_on, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule